// File: doc/BRIEF.md
# Sequenced Parallel ADC Readout Controller

This block runs a dual simultaneous-sampling ADC that has a 16-bit parallel data bus and its own internal channel sequencer enabled. Once enabled, it drives the converter's reset pin low for a short pulse and then waits through a long start-up interval. After that it repeats a measurement round without stopping. In each round it raises the conversion-start line once and waits for the converter's busy line to fall. It then reads every sequenced channel in ascending order. Each channel is read as a pair of words, the A-side word followed by the B-side word, and both are fetched inside one chip-select window using two read strobes.

Each captured word goes into a per-channel result register, one bank for the A side and one for the B side. A one-cycle valid pulse that carries the channel index accompanies every word. All timing is given in nanoseconds as parameters and converted to clock cycles by rounding up against the clock-period parameter. The analog range pins and the oversampling pins are driven from parameters as static configuration.

Top module: `seqadc_reader`

## Requirements
- R1: While `rst_n` is low, `adc_cs_n`, `adc_rd_n` and `adc_reset_n` are 1, `adc_conv` is 0, both valid outputs are 0 and every result slot is 0. The same idle levels hold while `en` stays low after reset.
- R2: One clock edge after `en` is first seen high in idle, `adc_reset_n` goes low for ceil(RST_LOW_NS/CLK_NS) cycles. The bus then stays idle for ceil(STARTUP_NS/CLK_NS) cycles before the first conversion, and chip-select stays high while reset is low.
- R3: Every round starts with `adc_conv` high for exactly ceil(CONV_NS/CLK_NS) cycles, with chip-select and read high. After the last channel of a round, chip-select stays high for ceil(QUIET_NS/CLK_NS) cycles before the next conversion pulse.
- R4: `adc_busy` passes through a SYNC_STAGES-flop synchronizer (default 2). A fall is flagged when the oldest stage is 1 and the one before it is 0. Chip-select falls one edge after the flag, and only if the controller is waiting for busy. Busy activity at any other time has no effect.
- R5: Chip-select falls ceil(CS_LEAD_NS/CLK_NS) cycles before the first read falling edge of a pair. Read never goes low while chip-select is high.
- R6: Each read strobe stays low for max(ceil(RD_LOW_NS/CLK_NS), ceil(SAMPLE_NS/CLK_NS)+1) cycles. `adc_data` is captured at the clock edge that falls ceil(SAMPLE_NS/CLK_NS) edges after the edge that lowered read.
- R7: Read is high for ceil(RD_GAP_NS/CLK_NS) cycles between the A and B strobes. Read is high for ceil(RD_HOLD_NS/CLK_NS) cycles after the B strobe before chip-select rises. Chip-select is high for ceil(CS_GAP_NS/CLK_NS) cycles between two pairs of the same round.
- R8: Within a round, pairs are read for channel 0 up to SEQ_LEN-1, and the channel counter restarts at 0 with each conversion pulse. The A word of channel c is stored in `res_a[16c+15:16c]` and the B word in `res_b[16c+15:16c]`. All other slots keep their values.
- R9: `a_valid` is high for one cycle, in the cycle after an A capture, with `valid_ch` equal to the channel. `b_valid` behaves the same way for B captures. The two are never high together, and each is high only while chip-select and read are low.
- R10: If `en` is low at a clock edge, the next cycle shows chip-select and read high and conversion low, and result slots that were not yet read keep their values. Raising `en` again restarts from the reset pulse of R2.
- R11: `range_sel` drives the RANGE_SEL parameter: 01 selects ±2.5 V (the default), 10 selects ±5 V and 11 selects ±10 V. `os_ratio` drives OS_RATIO (default 000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces idle |
| adc_busy | input | 1 | Converter busy line (asynchronous) |
| adc_data | input | DATA_W (16) | Parallel conversion data bus |
| adc_conv | output | 1 | Conversion-start pulse |
| adc_cs_n | output | 1 | Chip-select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_reset_n | output | 1 | Converter reset, active low |
| range_sel | output | 2 | Static analog range code |
| os_ratio | output | 3 | Static oversampling code |
| res_a | output | SEQ_LEN*DATA_W (128) | A-side result slots, channel c at bits 16c+15:16c |
| res_b | output | SEQ_LEN*DATA_W (128) | B-side result slots, same layout |
| a_valid | output | 1 | One-cycle pulse for a newly stored A word |
| b_valid | output | 1 | One-cycle pulse for a newly stored B word |
| valid_ch | output | CH_W (3) | Channel index of the word flagged valid |

## Verification
The bench places the data word on the bus only in the one cycle before the intended capture edge and drives its complement in every other cycle. A capture one edge early or late therefore stores the wrong word instead of the right one. It pulses busy while the controller is still in its start-up wait and changes the busy width from round to round. A design that reacts to an early fall, or that counts the synchronizer latency wrongly, shifts or starts the whole read window and fails on every following cycle. Enable is dropped in the middle of a round while chip-select is low. This checks that the strobes return to idle on the next edge, that slots not yet read keep their earlier words, and that re-enabling repeats the reset pulse. A channel counter that did not restart at the conversion pulse would write the following round into the wrong slots, and the end-of-round comparisons would catch that.

// File: rtl/seqadc_pkg.sv
package seqadc_pkg;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_RST_LO,
      PH_RST_WAIT,
      PH_CONV,
      PH_BUSY,
      PH_CS_LEAD,
      PH_A_LOW,
      PH_A_HIGH,
      PH_B_LOW,
      PH_B_HOLD,
      PH_CS_GAP,
      PH_QUIET
   } phase_t;

   // Round a nanosecond interval up to whole cycles, never below one.
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
      int unsigned c;
      c = (ns + period - 1) / period;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/seqadc_busy_sync.sv
module seqadc_busy_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_async,
   output logic busy_fall
);
   logic [STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[STAGES-2:0], busy_async};
   end

   // oldest stage high, next stage low: busy has just fallen
   assign busy_fall = sync_q[STAGES-1] & ~sync_q[STAGES-2];

endmodule

// File: rtl/seqadc_seq_fsm.sv
module seqadc_seq_fsm
   import seqadc_pkg::*;
#(
   parameter int unsigned SEQ_LEN = 8,
   parameter int unsigned N_RSTL  = 150,
   parameter int unsigned N_WAIT  = 1875000,
   parameter int unsigned N_CONV  = 7,
   parameter int unsigned N_CS    = 3,
   parameter int unsigned N_RDL   = 4,
   parameter int unsigned N_SAMP  = 3,
   parameter int unsigned N_RDH   = 2,
   parameter int unsigned N_HOLD  = 2,
   parameter int unsigned N_CSH   = 2,
   parameter int unsigned N_QUIET = 7,
   localparam int unsigned CH_W   = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            busy_fall,
   output logic            conv,
   output logic            cs_n,
   output logic            rd_n,
   output logic            reset_n,
   output logic            cap_a,
   output logic            cap_b,
   output logic [CH_W-1:0] ch
);
   localparam int unsigned N_MAX = umax(umax(umax(N_RSTL, N_WAIT), umax(N_CONV, N_CS)),
                                        umax(umax(N_RDL, N_RDH), umax(umax(N_HOLD, N_CSH), N_QUIET)));
   localparam int unsigned CNT_W = $clog2(N_MAX + 1);

   phase_t           ph, ph_nx;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] dur;
   logic             at_end;
   logic             last_ch;

   always_comb begin
      case (ph)
         PH_RST_LO:   dur = CNT_W'(N_RSTL);
         PH_RST_WAIT: dur = CNT_W'(N_WAIT);
         PH_CONV:     dur = CNT_W'(N_CONV);
         PH_CS_LEAD:  dur = CNT_W'(N_CS);
         PH_A_LOW,
         PH_B_LOW:    dur = CNT_W'(N_RDL);
         PH_A_HIGH:   dur = CNT_W'(N_RDH);
         PH_B_HOLD:   dur = CNT_W'(N_HOLD);
         PH_CS_GAP:   dur = CNT_W'(N_CSH);
         PH_QUIET:    dur = CNT_W'(N_QUIET);
         default:     dur = CNT_W'(1);
      endcase
   end

   assign at_end = (cnt == dur - 1'b1);

   always_comb begin
      ph_nx = ph;
      case (ph)
         PH_IDLE:     ph_nx = PH_RST_LO;
         PH_RST_LO:   if (at_end) ph_nx = PH_RST_WAIT;
         PH_RST_WAIT: if (at_end) ph_nx = PH_CONV;
         PH_CONV:     if (at_end) ph_nx = PH_BUSY;
         PH_BUSY:     if (busy_fall) ph_nx = PH_CS_LEAD;
         PH_CS_LEAD:  if (at_end) ph_nx = PH_A_LOW;
         PH_A_LOW:    if (at_end) ph_nx = PH_A_HIGH;
         PH_A_HIGH:   if (at_end) ph_nx = PH_B_LOW;
         PH_B_LOW:    if (at_end) ph_nx = PH_B_HOLD;
         PH_B_HOLD:   if (at_end) ph_nx = last_ch ? PH_QUIET : PH_CS_GAP;
         PH_CS_GAP:   if (at_end) ph_nx = PH_CS_LEAD;
         PH_QUIET:    if (at_end) ph_nx = PH_CONV;
         default:     ph_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else if (!en) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else begin
         ph  <= ph_nx;
         cnt <= (ph_nx != ph) ? '0 : cnt + 1'b1;
      end
   end

   generate
      if (SEQ_LEN == 1) begin : g_single
         assign ch      = '0;
         assign last_ch = 1'b1;
      end else begin : g_multi
         logic [CH_W-1:0] ch_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               ch_q <= '0;
            else if (!en || ph == PH_CONV)            ch_q <= '0;
            else if (ph == PH_B_HOLD && at_end && !last_ch) ch_q <= ch_q + 1'b1;
         end
         assign ch      = ch_q;
         assign last_ch = (ch_q == CH_W'(SEQ_LEN - 1));
      end
   endgenerate

   assign cap_a   = en && (ph == PH_A_LOW) && (cnt == CNT_W'(N_SAMP - 1));
   assign cap_b   = en && (ph == PH_B_LOW) && (cnt == CNT_W'(N_SAMP - 1));

   assign conv    = (ph == PH_CONV);
   assign reset_n = (ph != PH_RST_LO);
   assign rd_n    = !((ph == PH_A_LOW) || (ph == PH_B_LOW));
   assign cs_n    = !((ph == PH_CS_LEAD) || (ph == PH_A_LOW) || (ph == PH_A_HIGH) ||
                      (ph == PH_B_LOW) || (ph == PH_B_HOLD));

endmodule

// File: rtl/seqadc_result_bank.sv
module seqadc_result_bank #(
   parameter int unsigned SEQ_LEN = 8,
   parameter int unsigned DATA_W  = 16,
   localparam int unsigned CH_W   = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cap,
   input  logic [CH_W-1:0]           ch,
   input  logic [DATA_W-1:0]         din,
   output logic [SEQ_LEN*DATA_W-1:0] words,
   output logic                      vld,
   output logic [CH_W-1:0]           vld_ch
);
   for (genvar g = 0; g < SEQ_LEN; g++) begin : g_slot
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         word_q <= '0;
         else if (cap && ch == CH_W'(g))     word_q <= din;
      end
      assign words[g*DATA_W +: DATA_W] = word_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld    <= 1'b0;
         vld_ch <= '0;
      end else begin
         vld <= cap;
         if (cap) vld_ch <= ch;
      end
   end

endmodule

// File: rtl/seqadc_reader.sv
module seqadc_reader
   import seqadc_pkg::*;
#(
   parameter int unsigned CLK_NS      = 8,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SEQ_LEN     = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RST_LOW_NS  = 1200,
   parameter int unsigned STARTUP_NS  = 15000000,
   parameter int unsigned CONV_NS     = 50,
   parameter int unsigned CS_LEAD_NS  = 20,
   parameter int unsigned RD_LOW_NS   = 30,
   parameter int unsigned SAMPLE_NS   = 20,
   parameter int unsigned RD_GAP_NS   = 10,
   parameter int unsigned RD_HOLD_NS  = 10,
   parameter int unsigned CS_GAP_NS   = 10,
   parameter int unsigned QUIET_NS    = 50,
   parameter logic [1:0]  RANGE_SEL   = 2'b01,
   parameter logic [2:0]  OS_RATIO    = 3'b000,
   localparam int unsigned CH_W       = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic                      adc_busy,
   input  logic [DATA_W-1:0]         adc_data,
   output logic                      adc_conv,
   output logic                      adc_cs_n,
   output logic                      adc_rd_n,
   output logic                      adc_reset_n,
   output logic [1:0]                range_sel,
   output logic [2:0]                os_ratio,
   output logic [SEQ_LEN*DATA_W-1:0] res_a,
   output logic [SEQ_LEN*DATA_W-1:0] res_b,
   output logic                      a_valid,
   output logic                      b_valid,
   output logic [CH_W-1:0]           valid_ch
);
   localparam int unsigned N_SAMP = ns_to_cyc(SAMPLE_NS, CLK_NS);
   localparam int unsigned N_RDL  = umax(ns_to_cyc(RD_LOW_NS, CLK_NS), N_SAMP + 1);

   if (CLK_NS == 0)                   begin : g_bad_clk   $error("CLK_NS must be nonzero"); end
   if (SEQ_LEN < 1 || SEQ_LEN > 8)    begin : g_bad_seq   $error("SEQ_LEN must be 1..8"); end
   if (SYNC_STAGES < 2)               begin : g_bad_sync  $error("SYNC_STAGES must be >= 2"); end
   if (RANGE_SEL == 2'b00)            begin : g_bad_range $error("RANGE_SEL 00 is not a valid range"); end
   if (DATA_W == 0)                   begin : g_bad_width $error("DATA_W must be nonzero"); end

   logic            busy_fall;
   logic            cap_a, cap_b;
   logic [CH_W-1:0] ch;
   logic [CH_W-1:0] ch_a, ch_b;

   seqadc_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_async (adc_busy),
      .busy_fall  (busy_fall)
   );

   seqadc_seq_fsm #(
      .SEQ_LEN (SEQ_LEN),
      .N_RSTL  (ns_to_cyc(RST_LOW_NS, CLK_NS)),
      .N_WAIT  (ns_to_cyc(STARTUP_NS, CLK_NS)),
      .N_CONV  (ns_to_cyc(CONV_NS, CLK_NS)),
      .N_CS    (ns_to_cyc(CS_LEAD_NS, CLK_NS)),
      .N_RDL   (N_RDL),
      .N_SAMP  (N_SAMP),
      .N_RDH   (ns_to_cyc(RD_GAP_NS, CLK_NS)),
      .N_HOLD  (ns_to_cyc(RD_HOLD_NS, CLK_NS)),
      .N_CSH   (ns_to_cyc(CS_GAP_NS, CLK_NS)),
      .N_QUIET (ns_to_cyc(QUIET_NS, CLK_NS))
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .busy_fall (busy_fall),
      .conv      (adc_conv),
      .cs_n      (adc_cs_n),
      .rd_n      (adc_rd_n),
      .reset_n   (adc_reset_n),
      .cap_a     (cap_a),
      .cap_b     (cap_b),
      .ch        (ch)
   );

   seqadc_result_bank #(.SEQ_LEN(SEQ_LEN), .DATA_W(DATA_W)) u_bank_a (
      .clk (clk), .rst_n (rst_n), .cap (cap_a), .ch (ch), .din (adc_data),
      .words (res_a), .vld (a_valid), .vld_ch (ch_a)
   );

   seqadc_result_bank #(.SEQ_LEN(SEQ_LEN), .DATA_W(DATA_W)) u_bank_b (
      .clk (clk), .rst_n (rst_n), .cap (cap_b), .ch (ch), .din (adc_data),
      .words (res_b), .vld (b_valid), .vld_ch (ch_b)
   );

   assign valid_ch  = a_valid ? ch_a : ch_b;
   assign range_sel = RANGE_SEL;
   assign os_ratio  = OS_RATIO;

endmodule

// File: rtl/seqadc_reader_chk.sv
module seqadc_reader_chk
   import seqadc_pkg::*;
#(
   parameter int unsigned CLK_NS    = 8,
   parameter int unsigned RD_LOW_NS = 30,
   parameter int unsigned SAMPLE_NS = 20
) (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic adc_conv,
   input logic adc_cs_n,
   input logic adc_rd_n,
   input logic adc_reset_n,
   input logic a_valid,
   input logic b_valid
);
   localparam int unsigned N_RDL = umax(ns_to_cyc(RD_LOW_NS, CLK_NS), ns_to_cyc(SAMPLE_NS, CLK_NS) + 1);

   int unsigned rd_low_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rd_low_cnt <= 0;
      else if (!adc_rd_n) rd_low_cnt <= rd_low_cnt + 1;
      else               rd_low_cnt <= 0;
   end

   assert_reset_holds_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_reset_n |-> (adc_cs_n && !adc_conv));

   assert_conv_bus_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      adc_conv |-> (adc_cs_n && adc_rd_n));

   assert_rd_inside_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_rd_n |-> !adc_cs_n);

   assert_cs_falls_before_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cs_n) |-> adc_rd_n);

   assert_rd_low_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_rd_n) |-> ((rd_low_cnt >= N_RDL) || !$past(en)));

   assert_valid_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_valid && b_valid));

   assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (a_valid || b_valid) |=> !($past(a_valid) ? a_valid : b_valid));

   assert_valid_in_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (a_valid || b_valid) |-> (!adc_cs_n && !adc_rd_n));

   assert_disable_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (adc_cs_n && adc_rd_n && !adc_conv && adc_reset_n));

endmodule

bind seqadc_reader seqadc_reader_chk #(
   .CLK_NS    (CLK_NS),
   .RD_LOW_NS (RD_LOW_NS),
   .SAMPLE_NS (SAMPLE_NS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (en),
   .adc_conv    (adc_conv),
   .adc_cs_n    (adc_cs_n),
   .adc_rd_n    (adc_rd_n),
   .adc_reset_n (adc_reset_n),
   .a_valid     (a_valid),
   .b_valid     (b_valid)
);

// File: tb/seqadc_reader_bench.sv
module seqadc_reader_bench;
   localparam int T       = 8;
   localparam int SEQ     = 8;
   localparam int STARTUP = 400;

   function automatic int cdiv(input int ns);
      int c;
      c = (ns + T - 1) / T;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int C_RSTL  = cdiv(1200);
   localparam int C_WAIT  = cdiv(STARTUP);
   localparam int C_CONV  = cdiv(50);
   localparam int C_CS    = cdiv(20);
   localparam int C_SAMP  = cdiv(20);
   localparam int C_RDL   = (cdiv(30) > C_SAMP) ? cdiv(30) : C_SAMP + 1;
   localparam int C_RDH   = cdiv(10);
   localparam int C_HOLD  = cdiv(10);
   localparam int C_CSH   = cdiv(10);
   localparam int C_QUIET = cdiv(50);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic busy = 1'b0;
   logic [15:0] din = '0;
   logic conv, cs_n, rd_n, arst_n, a_vld, b_vld;
   logic [1:0] rsel;
   logic [2:0] osr, vch;
   logic [SEQ*16-1:0] res_a, res_b;

   int checks = 0;
   int errors = 0;
   logic [15:0] exp_a [SEQ];
   logic [15:0] exp_b [SEQ];

   always #4 clk = ~clk;

   seqadc_reader #(.CLK_NS(T), .STARTUP_NS(STARTUP)) u_seqadc_reader (
      .clk (clk), .rst_n (rst_n), .en (en), .adc_busy (busy), .adc_data (din),
      .adc_conv (conv), .adc_cs_n (cs_n), .adc_rd_n (rd_n), .adc_reset_n (arst_n),
      .range_sel (rsel), .os_ratio (osr), .res_a (res_a), .res_b (res_b),
      .a_valid (a_vld), .b_valid (b_vld), .valid_ch (vch)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // one cycle: compare at the falling edge, then drive the next inputs
   task automatic step(input string req, input bit e_conv, input bit e_cs, input bit e_rd,
                       input bit e_rst, input bit e_av, input bit e_bv, input int e_ch,
                       input logic [15:0] e_word, input logic [15:0] d, input bit b);
      @(negedge clk);
      chk(req, "adc_conv", 32'(conv), 32'(e_conv));
      chk(req, "adc_cs_n", 32'(cs_n), 32'(e_cs));
      chk(req, "adc_rd_n", 32'(rd_n), 32'(e_rd));
      chk(req, "adc_reset_n", 32'(arst_n), 32'(e_rst));
      chk("R9", "a_valid", 32'(a_vld), 32'(e_av));
      chk("R9", "b_valid", 32'(b_vld), 32'(e_bv));
      if (e_av || e_bv) chk("R9", "valid_ch", 32'(vch), 32'(e_ch));
      if (e_av) chk("R6", "res_a word", 32'(res_a[e_ch*16 +: 16]), 32'(e_word));
      if (e_bv) chk("R6", "res_b word", 32'(res_b[e_ch*16 +: 16]), 32'(e_word));
      din  = d;
      busy = b;
   endtask

   task automatic idle(input int n, input string req);
      for (int k = 0; k < n; k++) step(req, 0, 1, 1, 1, 0, 0, 0, '0, '0, 0);
   endtask

   task automatic startup();
      for (int k = 0; k < C_RSTL; k++) step("R2", 0, 1, 1, 0, 0, 0, 0, '0, '0, 0);
      // busy pulse during the start-up wait must be ignored (R4)
      for (int k = 0; k < C_WAIT; k++) step("R4", 0, 1, 1, 1, 0, 0, 0, '0, '0, (k >= 5 && k < 9));
   endtask

   task automatic check_slots(input string req);
      for (int c = 0; c < SEQ; c++) begin
         chk(req, "res_a slot", 32'(res_a[c*16 +: 16]), 32'(exp_a[c]));
         chk(req, "res_b slot", 32'(res_b[c*16 +: 16]), 32'(exp_b[c]));
      end
   endtask

   task automatic round(input int r, input int bsy, input int abort_ch);
      logic [15:0] wa, wb;
      for (int k = 0; k < C_CONV; k++) step("R3", 1, 1, 1, 1, 0, 0, 0, '0, '0, 0);
      for (int j = 0; j < bsy + 2; j++) step("R4", 0, 1, 1, 1, 0, 0, 0, '0, '0, (j < bsy));
      for (int c = 0; c < SEQ; c++) begin
         wa = 16'((r << 12) | (c << 8) | 8'h5A);
         wb = wa ^ 16'h0FF0;
         if (c == abort_ch) begin
            step("R5", 0, 0, 1, 1, 0, 0, 0, '0, ~wa, 0);
            en = 1'b0;
            idle(4, "R10");
            return;
         end
         for (int k = 0; k < C_CS; k++) step("R5", 0, 0, 1, 1, 0, 0, 0, '0, ~wa, 0);
         for (int k = 0; k < C_RDL; k++) begin
            if (k == C_SAMP) exp_a[c] = wa;
            step("R6", 0, 0, 0, 1, (k == C_SAMP), 0, c, wa, (k == C_SAMP - 1) ? wa : ~wa, 0);
         end
         for (int k = 0; k < C_RDH; k++) step("R7", 0, 0, 1, 1, 0, 0, 0, '0, ~wb, 0);
         for (int k = 0; k < C_RDL; k++) begin
            if (k == C_SAMP) exp_b[c] = wb;
            step("R6", 0, 0, 0, 1, 0, (k == C_SAMP), c, wb, (k == C_SAMP - 1) ? wb : ~wb, 0);
         end
         for (int k = 0; k < C_HOLD; k++) step("R7", 0, 0, 1, 1, 0, 0, 0, '0, '0, 0);
         if (c < SEQ - 1) begin
            for (int k = 0; k < C_CSH; k++) step("R7", 0, 1, 1, 1, 0, 0, 0, '0, '0, 0);
         end else begin
            for (int k = 0; k < C_QUIET; k++) step("R3", 0, 1, 1, 1, 0, 0, 0, '0, '0, 0);
         end
      end
      check_slots("R8");
   endtask

   initial begin
      for (int c = 0; c < SEQ; c++) begin
         exp_a[c] = '0;
         exp_b[c] = '0;
      end
      idle(3, "R1");
      check_slots("R1");
      rst_n = 1'b1;
      idle(3, "R1");
      chk("R11", "range_sel", 32'(rsel), 32'h1);
      chk("R11", "os_ratio", 32'(osr), 32'h0);
      en = 1'b1;
      startup();
      round(0, 4, -1);
      round(1, 9, -1);
      round(2, 2, 3);
      check_slots("R10");
      idle(3, "R10");
      en = 1'b1;
      startup();
      round(3, 1, -1);
      chk("R11", "range_sel", 32'(rsel), 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule